// File: doc/BRIEF.md
# Edge and Level Interrupt Source Bank

This block gathers 32 interrupt sources into one request line for a processor. Each input is either edge-sensitive or level-sensitive, and a build-time mask picks which. Edge inputs latch a sticky flag when they rise. Software clears that flag by writing ones to a clear register. Level inputs are not latched: their live, synchronized state is reported directly.

A software-written enable word gates both kinds of input. One registered request output is raised while any enabled source is pending. A registered index names the highest-numbered pending source, so a handler can go straight to it.

Software reaches the block through a plain 32-bit word register port with four slots. The address is a byte offset, and bits [3:2] pick the slot:

| Offset | Slot |
|---|---|
| 0x0 | edge flags |
| 0x4 | enable |
| 0x8 | clear |
| 0xC | live levels |

Bit n of every slot belongs to source n.

Top module: `irq_bank`

## Requirements
- R1: After reset, irq_out is 0, irq_idx is 0, and reads of offset 0x4 (enable) and 0x0 (edge flags) return 0.
- R2: A read of offset 0x4 returns exactly the last word written to offset 0x4.
- R3: A rising edge on a source outside LEVEL_MASK sets bit n of the edge-flag word (offset 0x0), whatever the enable state. The bit stays set after the input falls.
- R4: Writing offset 0x8 clears every edge flag whose write-data bit is 1 and leaves flags under 0 bits unchanged. A read of offset 0x8 returns 0.
- R5: A flag that is newly set in the same cycle as a clear write naming it stays set.
- R6: Writes to offset 0x0 have no effect on the edge flags.
- R7: A read of offset 0xC returns the synchronized live state of all 32 inputs. Sources inside LEVEL_MASK never set edge flags.
- R8: The pending word is (flags OR (levels AND LEVEL_MASK)) AND enable. irq_out is 1 exactly one cycle after the pending word becomes nonzero and 0 one cycle after it becomes zero.
- R9: Enabling an edge source whose input is already high, with its flag clear, raises no request. Only a later low-to-high transition does.
- R10: irq_idx is the number of the highest-numbered pending source, registered together with irq_out, and is 0 when nothing is pending.
- R11: Writing 0 to offset 0x4 drops irq_out on the next cycle even while flags remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset; bits [3:2] select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_in | input | 32 | Asynchronous interrupt inputs |
| irq_out | output | 1 | Request to the processor |
| irq_idx | output | 5 | Highest-numbered pending source |

## Verification
All timings count from the cycle in which a stimulus is driven:

| Stimulus | Result | Cycles later |
|---|---|---|
| Edge input rises | flag readable | 3 |
| Edge input rises | irq_out and irq_idx update | 4 |
| Level input changes | live-level read and pending word update | 2 |
| Level input changes | request updates | 3 |
| Register write takes effect | irq_out update | 1 |

Each stimulus task pushes the expected request and index into a scoreboard tagged with the exact cycle it is due. The monitor compares on the falling edge of that cycle. Where useful, one cycle earlier is also checked to confirm nothing arrives early. Register reads are combinational and are compared straight after the driving edge. The same-cycle set-and-clear case is timed so that the clear write lands on the edge where the flag is captured.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int NSRC  = 32;
    localparam int IDX_W = $clog2(NSRC);
    localparam int ADR_W = 4;

    typedef enum logic [1:0] {
        SEL_FLAGS  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_LEVELS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             we;
        reg_sel_e         sel;
        logic [NSRC-1:0]  data;
    } bus_wr_t;

    function automatic logic [IDX_W-1:0] hi_index(input logic [NSRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture
    import irq_bank_pkg::*;
#(
    parameter logic [NSRC-1:0] EDGE_MASK = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] lvl_sync,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] flags_q
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr_eff;

    assign rise    = lvl_sync & ~prev_q & EDGE_MASK;
    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= lvl_sync;
            flags_q <= (flags_q & ~clr_eff) | rise;
        end
    end

    // R4
    property clr_works_chk;
        @(posedge clk) disable iff (rst)
        clr_we |=> ((flags_q & $past(clr_bits & ~rise)) == '0);
    endproperty
    assert property (clr_works_chk);

    // R3
    property flag_needs_edge_chk;
        @(posedge clk) disable iff (rst)
        1'b1 |=> (((flags_q & ~$past(flags_q)) & ~$past(rise)) == '0);
    endproperty
    assert property (flag_needs_edge_chk);
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  pend_vec,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_num
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_num   <= '0;
        end else begin
            irq_valid <= |pend_vec;
            irq_num   <= hi_index(pend_vec);
        end
    end

    // R10
    property top_pending_chk;
        @(posedge clk) disable iff (rst)
        irq_valid |-> (($past(pend_vec) >> irq_num) == NSRC'(1));
    endproperty
    assert property (top_pending_chk);
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter logic [31:0] LEVEL_MASK  = 32'h3FF0_0000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [ADR_W-1:0] reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [31:0]      src_in,
    output logic             irq_out,
    output logic [IDX_W-1:0] irq_idx
);
    bus_wr_t         bw;
    logic [NSRC-1:0] lvl_sync;
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend;
    reg_sel_e        rsel;

    assign rsel    = reg_sel_e'(reg_addr[3:2]);
    assign bw.we   = reg_wr;
    assign bw.sel  = rsel;
    assign bw.data = reg_wdata;

    irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (src_in),
        .sync_out (lvl_sync)
    );

    irq_capture #(.EDGE_MASK(~LEVEL_MASK)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .lvl_sync (lvl_sync),
        .clr_we   (bw.we && bw.sel == SEL_CLEAR),
        .clr_bits (bw.data),
        .flags_q  (flags_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bw.we && bw.sel == SEL_ENABLE) begin
            en_q <= bw.data;
        end
    end

    assign pend = (flags_q | (lvl_sync & LEVEL_MASK)) & en_q;

    irq_prio u_prio (
        .clk       (clk),
        .rst       (rst),
        .pend_vec  (pend),
        .irq_valid (irq_out),
        .irq_num   (irq_idx)
    );

    always_comb begin
        unique case (rsel)
            SEL_FLAGS:  reg_rdata = flags_q;
            SEL_ENABLE: reg_rdata = en_q;
            SEL_CLEAR:  reg_rdata = '0;
            SEL_LEVELS: reg_rdata = lvl_sync;
            default:    reg_rdata = '0;
        endcase
    end

    // R2
    property en_readback_chk;
        @(posedge clk) disable iff (rst)
        (reg_wr && rsel == SEL_ENABLE) |=> (en_q == $past(reg_wdata));
    endproperty
    assert property (en_readback_chk);

    // R11
    property all_off_quiet_chk;
        @(posedge clk) disable iff (rst)
        (en_q == '0) |=> !irq_out;
    endproperty
    assert property (all_off_quiet_chk);
endmodule

// File: tb/sim_irq_bank.sv
module sim_irq_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] src_in = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic [4:0]  irq_idx;

    always #4 clk = ~clk;

    irq_bank #(.LEVEL_MASK(32'h3FF0_0000)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
        .irq_out(irq_out), .irq_idx(irq_idx)
    );

    typedef struct {
        int         due;
        logic       o;
        logic [4:0] idx;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            e = sb.pop_front();
            n_cmp++;
            if (irq_out !== e.o || irq_idx !== e.idx) begin
                n_bad++;
                $display("FAIL %s cyc %0d: irq_out/idx actual %b/%0d expected %b/%0d",
                         e.req, cyc, irq_out, irq_idx, e.o, e.idx);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read 0x%0h: actual %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic expect_irq(input int dly, input logic o, input logic [4:0] idx, input string req);
        exp_t e;
        e.due = cyc + dly; e.o = o; e.idx = idx; e.req = req;
        sb.push_back(e);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        expect_irq(1, 0, 0, "R1");
        rd_chk(4'h4, 0, "R1");
        rd_chk(4'h0, 0, "R1");
        rd_chk(4'hC, 0, "R7");
        tick(2);

        // R2 enable readback
        wr(4'h4, 32'hA5A5_5A5A);
        rd_chk(4'h4, 32'hA5A5_5A5A, "R2");
        wr(4'h4, 32'h0);
        rd_chk(4'h4, 32'h0, "R2");

        // R3 / R8 edge capture and timing
        wr(4'h4, 32'h8);
        src_in[3] = 1'b1;
        expect_irq(3, 0, 0, "R8");
        expect_irq(4, 1, 3, "R3");
        tick(4);
        rd_chk(4'h0, 32'h8, "R3");
        src_in[3] = 1'b0;
        tick(3);
        rd_chk(4'h0, 32'h8, "R3");
        expect_irq(1, 1, 3, "R8");
        tick(1);

        // R4 clear register
        wr(4'h8, 32'hFFFF_FFF7);
        rd_chk(4'h0, 32'h8, "R4");
        expect_irq(1, 1, 3, "R4");
        tick(1);
        rd_chk(4'h8, 32'h0, "R4");
        wr(4'h8, 32'h8);
        expect_irq(1, 0, 0, "R4");
        rd_chk(4'h0, 32'h0, "R4");
        tick(2);

        // R6 writes to flag word ignored
        src_in[3] = 1'b1;
        tick(4);
        src_in[3] = 1'b0;
        wr(4'h0, 32'h0);
        rd_chk(4'h0, 32'h8, "R6");
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk(4'h0, 32'h8, "R6");
        wr(4'h8, 32'h8);
        tick(2);

        // R7 / R8 level source
        wr(4'h4, 32'h0040_0000);
        src_in[22] = 1'b1;
        expect_irq(2, 0, 0, "R8");
        expect_irq(3, 1, 22, "R7");
        tick(3);
        rd_chk(4'hC, 32'h0040_0000, "R7");
        rd_chk(4'h0, 32'h0, "R7");
        src_in[22] = 1'b0;
        expect_irq(2, 1, 22, "R8");
        expect_irq(3, 0, 0, "R8");
        tick(4);

        // R10 priority
        wr(4'h4, 32'h8040_0008);
        src_in[3] = 1'b1; src_in[22] = 1'b1;
        expect_irq(4, 1, 22, "R10");
        tick(4);
        src_in[31] = 1'b1;
        expect_irq(4, 1, 31, "R10");
        tick(4);
        src_in = '0;
        tick(3);
        wr(4'h8, 32'hFFFF_FFFF);
        expect_irq(1, 0, 0, "R10");
        tick(2);

        // R11 disable all while flag pending
        src_in[3] = 1'b1;
        tick(5);
        expect_irq(1, 1, 3, "R11");
        tick(1);
        wr(4'h4, 32'h0);
        expect_irq(1, 0, 0, "R11");
        rd_chk(4'h0, 32'h8, "R11");
        tick(2);
        wr(4'h8, 32'h8);
        src_in[3] = 1'b0;
        tick(3);

        // R9 enable on already-high input
        src_in[5] = 1'b1;
        tick(5);
        rd_chk(4'h0, 32'h20, "R3");
        wr(4'h8, 32'h20);
        rd_chk(4'h0, 32'h0, "R9");
        wr(4'h4, 32'h20);
        expect_irq(1, 0, 0, "R9");
        expect_irq(3, 0, 0, "R9");
        tick(4);
        rd_chk(4'h0, 32'h0, "R9");
        src_in[5] = 1'b0;
        tick(3);
        src_in[5] = 1'b1;
        expect_irq(4, 1, 5, "R9");
        tick(5);
        src_in[5] = 1'b0;
        wr(4'h8, 32'h20);
        wr(4'h4, 32'h0);
        tick(3);

        // R5 set and clear in the same cycle
        src_in[7] = 1'b1;
        tick(2);
        wr(4'h8, 32'h80);
        tick(1);
        rd_chk(4'h0, 32'h80, "R5");
        wr(4'h8, 32'h80);
        rd_chk(4'h0, 32'h0, "R5");
        src_in[7] = 1'b0;

        // R7 masked source never sets a flag
        src_in[29] = 1'b1;
        tick(5);
        rd_chk(4'hC, 32'h2000_0000, "R7");
        rd_chk(4'h0, 32'h0, "R7");
        src_in[29] = 1'b0;
        tick(4);

        done = 1;
        summary();
        $finish;
    end
endmodule